// File: doc/BRIEF.md
# Cache-Maintenance Coprocessor Operation Decoder

This block sits in a processor's system-control coprocessor path and turns an access to the cache-maintenance register space into a single operation request. Each access arrives as a one-cycle valid strobe carrying a read/write flag, a 4-bit CRm selector, a 3-bit opcode_2 selector, and the issuing context: privilege level and security state. The block then asserts exactly one of two outputs. The first is a one-hot operation code, which the cache, branch predictor, barrier or address-translation logic picks up. The second is an undefined-instruction exception pulse.

The legality rules depend on the operation. Only three operations may be issued from User mode. Reads are refused except for the translation result register. Translation requests that target the opposite security state are accepted only from the Secure privileged context. Any selector pair that names no operation is refused. The result is registered, so both outputs pulse in the cycle after the strobe. A translation request also reports its permission variant on a 2-bit side output.

Top module: `c7_op_decoder`

## Requirements
- R1: A read (`acc_read`=1) is legal only for CRm=4, opcode_2=0, and only when privileged; it sets `op_onehot` bit 16. Every other read raises `undef_exc` and sets no operation bit.
- R2: In User mode (`priv_mode`=0) the only legal accesses are writes to prefetch flush (CRm=5, op2=4, bit 2), data synchronization barrier (CRm=10, op2=4, bit 12) and data memory barrier (CRm=10, op2=5, bit 13). Every other User access raises `undef_exc`.
- R3: Privileged writes with CRm=5 decode as follows: op2=0 gives instruction cache invalidate-all with branch-target flush (bit 0), op2=1 gives instruction line invalidate by address (bit 1), op2=4 gives prefetch flush (bit 2), op2=6 gives predictor invalidate-all (bit 3), and op2=7 gives predictor invalidate by address (bit 4).
- R4: Privileged data-side line writes decode by CRm and op2, where op2=1 means by address and op2=2 means by set/way. CRm=6 is invalidate (bits 5 and 6). CRm=10 is clean to the point of coherency (bits 7 and 8). CRm=11 with op2=1 only is clean to the point of unification (bit 9). CRm=14 is clean-and-invalidate (bits 10 and 11).
- R5: A privileged write with CRm=8 and op2=0..3 is a current-state translation request (bit 14), legal in both security states. `xlat_perm` carries op2[1:0].
- R6: A write with CRm=8 and op2=4..7 is an other-state translation request (bit 15), legal only when privileged and Secure. `xlat_perm` carries op2[1:0], where 0 is privileged read, 1 privileged write, 2 User read and 3 User write. From any other context it raises `undef_exc`.
- R7: Barrier writes (bits 12 and 13) are accepted identically in both security states and at both privilege levels.
- R8: A write to the translation result register (CRm=4, op2=0) is legal only when privileged, and it sets bit 16+1 = bit 17.
- R9: Every CRm/opcode_2 pair not named in R1 to R8 raises `undef_exc` and sets no operation bit.
- R10: Outputs are registered one cycle after `acc_valid` and last one cycle. Exactly one of "some `op_onehot` bit" or `undef_exc` pulses per strobe, and both are zero in any cycle not preceded by a strobe. `xlat_perm` is zero unless bit 14 or 15 is set. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_read | input | 1 | 1 = read access, 0 = write access |
| acc_crm | input | 4 | CRm selector |
| acc_op2 | input | 3 | opcode_2 selector |
| priv_mode | input | 1 | 1 = privileged, 0 = User |
| secure_state | input | 1 | 1 = Secure, 0 = Nonsecure |
| op_onehot | output | 18 | One-hot operation pulse, bit map per R1 to R8 |
| xlat_perm | output | 2 | Permission variant of a translation request |
| undef_exc | output | 1 | Undefined-instruction exception pulse |

## Verification
The bench sweeps every combination of read/write, privilege, security state, CRm and opcode_2, which is 1024 accesses. It compares each against an expectation built from a lookup keyed on the selector pair. The privileged Secure and privileged Nonsecure sweeps separate the other-state translation group from everything else. The User sweeps confirm that only the prefetch flush and the two barriers pass. The read sweeps leave only the result-register read. Each strobe is followed by an idle cycle, which checks that every output returns to zero, and the unnamed selector pairs confirm that an exception is raised with no operation bit set.

// File: rtl/c7dec_pkg.sv
package c7dec_pkg;
  localparam int CRM_W = 4;
  localparam int OP2_W = 3;
  localparam int OP_W  = 18;
  localparam int PERM_W = 2;

  typedef enum int {
    OP_IC_INV_ALL    = 0,
    OP_IC_INV_ADDR   = 1,
    OP_PF_FLUSH      = 2,
    OP_BP_INV_ALL    = 3,
    OP_BP_INV_ADDR   = 4,
    OP_DC_INV_ADDR   = 5,
    OP_DC_INV_SW     = 6,
    OP_DC_CLN_C_ADDR = 7,
    OP_DC_CLN_SW     = 8,
    OP_DC_CLN_U_ADDR = 9,
    OP_DC_CI_ADDR    = 10,
    OP_DC_CI_SW      = 11,
    OP_DSB           = 12,
    OP_DMB           = 13,
    OP_XLAT_CUR      = 14,
    OP_XLAT_OTHER    = 15,
    OP_RES_RD        = 16,
    OP_RES_WR        = 17
  } op_idx_e;

  function automatic logic [OP_W-1:0] op_bit(input op_idx_e idx);
    logic [OP_W-1:0] one;
    one = OP_W'(1);
    return one << idx;
  endfunction

  function automatic logic [OP_W-1:0] user_ok_mask();
    return op_bit(OP_PF_FLUSH) | op_bit(OP_DSB) | op_bit(OP_DMB);
  endfunction

  function automatic logic [OP_W-1:0] secure_only_mask();
    return op_bit(OP_XLAT_OTHER);
  endfunction

  function automatic logic [OP_W-1:0] xlat_mask();
    return op_bit(OP_XLAT_CUR) | op_bit(OP_XLAT_OTHER);
  endfunction
endpackage

// File: rtl/c7_op_match.sv
module c7_op_match
  import c7dec_pkg::*;
(
  input  logic             is_read,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic [OP_W-1:0]  cand
);
  always_comb begin
    cand = '0;
    if (is_read) begin
      if (crm == CRM_W'(4) && op2 == OP2_W'(0)) cand = op_bit(OP_RES_RD);
    end else begin
      unique case (crm)
        CRM_W'(4): if (op2 == OP2_W'(0)) cand = op_bit(OP_RES_WR);
        CRM_W'(5): begin
          case (op2)
            OP2_W'(0): cand = op_bit(OP_IC_INV_ALL);
            OP2_W'(1): cand = op_bit(OP_IC_INV_ADDR);
            OP2_W'(4): cand = op_bit(OP_PF_FLUSH);
            OP2_W'(6): cand = op_bit(OP_BP_INV_ALL);
            OP2_W'(7): cand = op_bit(OP_BP_INV_ADDR);
            default:   cand = '0;
          endcase
        end
        CRM_W'(6): begin
          if (op2 == OP2_W'(1)) cand = op_bit(OP_DC_INV_ADDR);
          else if (op2 == OP2_W'(2)) cand = op_bit(OP_DC_INV_SW);
        end
        CRM_W'(8): cand = op2[OP2_W-1] ? op_bit(OP_XLAT_OTHER) : op_bit(OP_XLAT_CUR);
        CRM_W'(10): begin
          case (op2)
            OP2_W'(1): cand = op_bit(OP_DC_CLN_C_ADDR);
            OP2_W'(2): cand = op_bit(OP_DC_CLN_SW);
            OP2_W'(4): cand = op_bit(OP_DSB);
            OP2_W'(5): cand = op_bit(OP_DMB);
            default:   cand = '0;
          endcase
        end
        CRM_W'(11): if (op2 == OP2_W'(1)) cand = op_bit(OP_DC_CLN_U_ADDR);
        CRM_W'(14): begin
          if (op2 == OP2_W'(1)) cand = op_bit(OP_DC_CI_ADDR);
          else if (op2 == OP2_W'(2)) cand = op_bit(OP_DC_CI_SW);
        end
        default: cand = '0;
      endcase
    end
  end
endmodule

// File: rtl/c7_access_gate.sv
module c7_access_gate
  import c7dec_pkg::*;
(
  input  logic [OP_W-1:0] cand,
  input  logic            priv,
  input  logic            secure,
  output logic            legal
);
  logic named;
  logic user_pass;
  logic priv_pass;

  assign named     = |cand;
  assign user_pass = |(cand & user_ok_mask());
  assign priv_pass = ~(|(cand & secure_only_mask())) | secure;
  assign legal     = named & (priv ? priv_pass : user_pass);
endmodule

// File: rtl/c7_op_decoder.sv
module c7_op_decoder
  import c7dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic [CRM_W-1:0]  acc_crm,
  input  logic [OP2_W-1:0]  acc_op2,
  input  logic              priv_mode,
  input  logic              secure_state,
  output logic [OP_W-1:0]   op_onehot,
  output logic [PERM_W-1:0] xlat_perm,
  output logic              undef_exc
);
  logic [OP_W-1:0] cand;
  logic            legal;
  logic            accept;
  logic            refuse;
  logic            is_xlat;

  c7_op_match u_match (
    .is_read (acc_read),
    .crm     (acc_crm),
    .op2     (acc_op2),
    .cand    (cand)
  );

  c7_access_gate u_gate (
    .cand   (cand),
    .priv   (priv_mode),
    .secure (secure_state),
    .legal  (legal)
  );

  assign accept  = acc_valid & legal;
  assign refuse  = acc_valid & ~legal;
  assign is_xlat = |(cand & xlat_mask());

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_onehot <= '0;
      xlat_perm <= '0;
      undef_exc <= 1'b0;
    end else begin
      op_onehot <= accept ? cand : '0;
      xlat_perm <= (accept && is_xlat) ? acc_op2[PERM_W-1:0] : '0;
      undef_exc <= refuse;
    end
  end
endmodule

// File: rtl/c7_op_decoder_chk.sv
module c7_op_decoder_chk
  import c7dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_read,
  input logic              priv_mode,
  input logic              secure_state,
  input logic [OP_W-1:0]   op_onehot,
  input logic [PERM_W-1:0] xlat_perm,
  input logic              undef_exc
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_exc, op_onehot})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid && rst_n) |-> (op_onehot == '0 && !undef_exc)); // R10

  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && rst_n) |-> ((|op_onehot) || undef_exc)); // R10

  AST_USER_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && rst_n && !priv_mode) |-> ((op_onehot & ~user_ok_mask()) == '0)); // R2

  AST_READ_ONLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && rst_n && acc_read) |-> ((op_onehot & ~op_bit(OP_RES_RD)) == '0)); // R1

  AST_OTHER_STATE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    op_onehot[OP_XLAT_OTHER] |-> $past(priv_mode && secure_state)); // R6

  AST_PERM_ONLY_XLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_perm != '0) |-> (|(op_onehot & xlat_mask()))); // R10
endmodule

bind c7_op_decoder c7_op_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_read     (acc_read),
  .priv_mode    (priv_mode),
  .secure_state (secure_state),
  .op_onehot    (op_onehot),
  .xlat_perm    (xlat_perm),
  .undef_exc    (undef_exc)
);

// File: tb/sim_c7_op_decoder.sv
module sim_c7_op_decoder;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_read = 1'b0;
  logic [3:0]  acc_crm = '0;
  logic [2:0]  acc_op2 = '0;
  logic        priv_mode = 1'b0;
  logic        secure_state = 1'b0;
  logic [17:0] op_onehot;
  logic [1:0]  xlat_perm;
  logic        undef_exc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  c7_op_decoder u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_read(acc_read),
    .acc_crm(acc_crm), .acc_op2(acc_op2), .priv_mode(priv_mode),
    .secure_state(secure_state), .op_onehot(op_onehot),
    .xlat_perm(xlat_perm), .undef_exc(undef_exc)
  );

  // Operation index named by a selector pair, -1 when none
  function automatic int code_of(input logic rd, input logic [3:0] crm, input logic [2:0] op2);
    if (rd) return (crm == 4'd4 && op2 == 3'd0) ? 16 : -1;
    case ({crm, op2})
      {4'd4, 3'd0}: return 17;
      {4'd5, 3'd0}: return 0;
      {4'd5, 3'd1}: return 1;
      {4'd5, 3'd4}: return 2;
      {4'd5, 3'd6}: return 3;
      {4'd5, 3'd7}: return 4;
      {4'd6, 3'd1}: return 5;
      {4'd6, 3'd2}: return 6;
      {4'd10, 3'd1}: return 7;
      {4'd10, 3'd2}: return 8;
      {4'd11, 3'd1}: return 9;
      {4'd14, 3'd1}: return 10;
      {4'd14, 3'd2}: return 11;
      {4'd10, 3'd4}: return 12;
      {4'd10, 3'd5}: return 13;
      default: return (crm == 4'd8) ? ((op2 >= 3'd4) ? 15 : 14) : -1;
    endcase
  endfunction

  function automatic string tag_of(input logic rd, input logic pv, input int c,
                                   input logic [3:0] crm, input logic [2:0] op2);
    if (rd) return "R1";
    if (c == 12 || c == 13) return "R7";
    if (!pv) return "R2";
    if (c < 0) return "R9";
    if (crm == 4'd5) return "R3";
    if (crm == 4'd4) return "R8";
    if (crm == 4'd8) return (op2 >= 3'd4) ? "R6" : "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [17:0] e_op,
                       input logic [1:0] e_perm, input logic e_und);
    n_chk++;
    if (op_onehot !== e_op || xlat_perm !== e_perm || undef_exc !== e_und) begin
      n_bad++;
      $display("FAIL %s: got op=%h perm=%0d und=%b expected op=%h perm=%0d und=%b",
               tag, op_onehot, xlat_perm, undef_exc, e_op, e_perm, e_und);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", '0, '0, 1'b0);      // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", '0, '0, 1'b0);      // idle after reset
    for (int rd = 0; rd < 2; rd++)
      for (int pv = 0; pv < 2; pv++)
        for (int sc = 0; sc < 2; sc++)
          for (int cm = 0; cm < 16; cm++)
            for (int o2 = 0; o2 < 8; o2++) begin
              int c;
              logic legal;
              logic [17:0] e_op;
              logic [1:0]  e_perm;
              c = code_of(rd[0], cm[3:0], o2[2:0]);
              if (c < 0) legal = 1'b0;
              else if (pv == 0) legal = (c == 2 || c == 12 || c == 13);
              else legal = (c != 15) || (sc == 1);
              e_op   = legal ? (18'd1 << c) : '0;
              e_perm = (legal && (c == 14 || c == 15)) ? o2[1:0] : 2'd0;
              acc_valid = 1'b1; acc_read = rd[0]; priv_mode = pv[0];
              secure_state = sc[0]; acc_crm = cm[3:0]; acc_op2 = o2[2:0];
              @(negedge clk);
              check(tag_of(rd[0], pv[0], c, cm[3:0], o2[2:0]), e_op, e_perm, ~legal);
              acc_valid = 1'b0;
              @(negedge clk);
              check("R10", '0, '0, 1'b0); // pulse ends, idle is quiet
            end
    // reset mid-operation clears outputs
    acc_valid = 1'b1; acc_read = 1'b0; priv_mode = 1'b1; acc_crm = 4'd10; acc_op2 = 3'd4;
    @(negedge clk);
    check("R7", 18'd1 << 12, '0, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R10", '0, '0, 1'b0);
    acc_valid = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10: watchdog expired, got no end expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule